// File: doc/BRIEF.md
# Multi-mode LED chaser controller

This block drives a row of eight LEDs with a moving-light pattern. A two-bit select input chooses one of three patterns. In the first, the row fills up from one end and then empties, using an inverted-feedback shift. In the second, a single lit LED circulates around the row. In the third, a single lit LED sweeps back and forth across the row.

All logic runs on one 50 MHz system clock. A prescaler counts clock cycles and gives a one-cycle step enable every `STEP_CYCLES` cycles. The default of 15,000,000 cycles is about 0.3 s per step. The pattern register moves only on that enable, so the design has no derived clocks.

When the select input picks a different pattern, the next step does not advance the pattern. It loads a legal starting state for the new pattern, so a one-hot pattern never starts from a multi-hot value.

Top module: `led_chaser`

## Requirements
- R1: While `rst_ni` is low, `led_o` is 8'h00. Asserting reset clears the LEDs at once, without waiting for a clock edge.
- R2: `led_o` changes only at the clock edge that ends each group of `STEP_CYCLES` cycles counted from reset release, and holds its value on every other edge.
- R3: Select codes 2'b00 and 2'b01 choose the fill/empty pattern. On each step `led_o` becomes `{led_o[6:0], ~led_o[7]}`. Starting from 8'h00, the pattern returns to 8'h00 after 16 steps.
- R4: Select code 2'b10 chooses the circulating pattern. On each step `led_o` becomes `{led_o[6:0], led_o[7]}`, so 8'h80 is followed by 8'h01 and the pattern repeats every 8 steps.
- R5: Select code 2'b11 chooses the sweep pattern. The lit bit moves toward `led_o[7]` until it reaches it, then moves toward `led_o[0]` until it reaches it, then turns again. Each end is lit for one step per turnaround, and a full cycle takes 14 steps.
- R6: On a step where the decoded pattern differs from the one currently running, `led_o` loads the starting state of the new pattern instead of advancing. The starting state is 8'h00 for the fill/empty pattern and 8'h01, moving upward, for the circulating and sweep patterns. This also applies when switching between the circulating and sweep patterns.
- R7: Changing the select between 2'b00 and 2'b01 is not a pattern change. The fill/empty sequence continues without reloading.
- R8: While a one-hot pattern (circulating or sweep) is running, exactly one bit of `led_o` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (50 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Pattern select, sampled at each step |
| led_o | output | 8 | LED drive, bit 0 is the first position |

## Verification
Two situations are hard to reach: a select change that falls exactly on a step edge while a one-hot pattern is in mid-sweep, and the turnaround at both ends of the sweep. At the default step period, reaching them would take many millions of cycles. The bench therefore overrides `STEP_CYCLES` to 5 and changes the select only between step edges. This lets it place a reload on a chosen step, including a switch from the sweep to the circulating pattern while the bit sits away from bit 0. The bench also follows a full 14-step sweep and counts how often each end is lit.

// File: rtl/chaser_pkg.sv
package chaser_pkg;
  typedef enum logic [1:0] {
    MODE_TWIST  = 2'd0,
    MODE_ROTATE = 2'd1,
    MODE_BOUNCE = 2'd2
  } chase_mode_e;

  // 2'b00 and 2'b01 both select the twisted fill/empty ring
  function automatic chase_mode_e decode_sel(input logic [1:0] sel);
    case (sel)
      2'b10:   return MODE_ROTATE;
      2'b11:   return MODE_BOUNCE;
      default: return MODE_TWIST;
    endcase
  endfunction
endpackage

// File: rtl/chaser_prescaler.sv
module chaser_prescaler #(
  parameter int STEP_CYCLES = 15_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int CNT_W = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign step_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/chaser_next.sv
module chaser_next
  import chaser_pkg::*;
#(
  parameter int LED_W = 8
) (
  input  chase_mode_e      mode_i,
  input  logic [LED_W-1:0] led_i,
  input  logic             up_i,
  output logic [LED_W-1:0] led_o,
  output logic             up_o
);
  logic [LED_W-1:0] shl, shr;

  assign shl = {led_i[LED_W-2:0], 1'b0};
  assign shr = {1'b0, led_i[LED_W-1:1]};

  always_comb begin
    led_o = led_i;
    up_o  = up_i;
    unique case (mode_i)
      MODE_TWIST:  led_o = {led_i[LED_W-2:0], ~led_i[LED_W-1]};
      MODE_ROTATE: led_o = {led_i[LED_W-2:0], led_i[LED_W-1]};
      MODE_BOUNCE: begin
        if (up_i) begin
          led_o = shl;
          up_o  = ~shl[LED_W-1];
        end else begin
          led_o = shr;
          up_o  = shr[0];
        end
      end
      default: led_o = led_i;
    endcase
  end
endmodule

// File: rtl/led_chaser.sv
module led_chaser
  import chaser_pkg::*;
#(
  parameter int STEP_CYCLES = 15_000_000,
  parameter int LED_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  output logic [LED_W-1:0] led_o
);
  localparam logic [LED_W-1:0] ONEHOT_START = LED_W'(1);

  logic             step_w;
  chase_mode_e      cur_mode, mode_q;
  logic [LED_W-1:0] led_q, led_nxt;
  logic             up_q, up_nxt;

  assign cur_mode = decode_sel(mode_i);

  chaser_prescaler #(.STEP_CYCLES(STEP_CYCLES)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_o(step_w)
  );

  chaser_next #(.LED_W(LED_W)) u_next (
    .mode_i(mode_q),
    .led_i (led_q),
    .up_i  (up_q),
    .led_o (led_nxt),
    .up_o  (up_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_q  <= '0;
      up_q   <= 1'b1;
      mode_q <= MODE_TWIST;
    end else if (step_w) begin
      if (cur_mode != mode_q) begin
        // reload a legal start state instead of advancing
        mode_q <= cur_mode;
        up_q   <= 1'b1;
        led_q  <= (cur_mode == MODE_TWIST) ? '0 : ONEHOT_START;
      end else begin
        led_q <= led_nxt;
        up_q  <= up_nxt;
      end
    end
  end

  assign led_o = led_q;
endmodule

// File: rtl/chaser_checker.sv
module chaser_checker #(
  parameter int LED_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic [1:0]       cur_mode_i,
  input logic [1:0]       mode_q_i,
  input logic [LED_W-1:0] led_i
);
  localparam logic [1:0] M_TWIST  = 2'd0;
  localparam logic [1:0] M_ROTATE = 2'd1;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_clear_R1: assert (led_i == '0);
  end

  assert_hold_between_steps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(led_i));

  assert_twist_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_q_i == M_TWIST && cur_mode_i == M_TWIST)
    |=> led_i == {$past(led_i[LED_W-2:0]), ~$past(led_i[LED_W-1])});

  assert_rotate_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mode_q_i == M_ROTATE && cur_mode_i == M_ROTATE)
    |=> led_i == {$past(led_i[LED_W-2:0]), $past(led_i[LED_W-1])});

  assert_reload_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cur_mode_i != mode_q_i)
    |=> led_i == ((mode_q_i == M_TWIST) ? '0 : LED_W'(1)));

  assert_single_lit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i != M_TWIST) |-> $countones(led_i) == 1);
endmodule

bind led_chaser chaser_checker #(.LED_W(LED_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .step_i    (step_w),
  .cur_mode_i(cur_mode),
  .mode_q_i  (mode_q),
  .led_i     (led_o)
);

// File: tb/sim_led_chaser.sv
`timescale 1ns/1ps
module sim_led_chaser;
  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic [1:0] sel = 2'b01;
  logic [7:0] led;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] exp_led = 8'h00;
  bit         exp_up  = 1'b1;
  int         exp_mode = 0;

  always #2 clk = ~clk;

  led_chaser #(.STEP_CYCLES(N), .LED_W(8)) u0 (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .mode_i(sel),
    .led_o (led)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: led=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dec(input logic [1:0] s);
    if (s == 2'b10) return 1;
    if (s == 2'b11) return 2;
    return 0;
  endfunction

  task automatic model_step();
    int d = dec(sel);
    if (d != exp_mode) begin
      exp_mode = d;
      exp_up   = 1'b1;
      exp_led  = (d == 0) ? 8'h00 : 8'h01;
    end else if (d == 0) begin
      exp_led = {exp_led[6:0], ~exp_led[7]};
    end else if (d == 1) begin
      exp_led = {exp_led[6:0], exp_led[7]};
    end else if (exp_up) begin
      exp_led = exp_led << 1;
      if (exp_led[7]) exp_up = 1'b0;
    end else begin
      exp_led = exp_led >> 1;
      if (exp_led[0]) exp_up = 1'b1;
    end
  endtask

  task automatic do_step(input string req);
    logic [7:0] prev = led;
    repeat (N - 1) @(posedge clk);
    #1 chk(led == prev, "R2 hold", led, prev);
    @(posedge clk);
    #1;
    model_step();
    chk(led == exp_led, req, led, exp_led);
  endtask

  task automatic t_reset();
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk(led == 8'h00, "R1", led, 8'h00);
    rst_ni = 1'b1;
  endtask

  task automatic t_twist();
    sel = 2'b01;
    for (int i = 0; i < 16; i++) do_step("R3");
    chk(led == 8'h00, "R3 period", led, 8'h00);
  endtask

  task automatic t_alias();
    sel = 2'b01;
    for (int i = 0; i < 3; i++) do_step("R3");
    sel = 2'b00;
    for (int i = 0; i < 2; i++) do_step("R7");
    chk(led == 8'h1F, "R7 continue", led, 8'h1F);
  endtask

  task automatic t_rotate();
    sel = 2'b10;
    do_step("R6 load");
    chk(led == 8'h01, "R6 rotate start", led, 8'h01);
    for (int i = 0; i < 8; i++) do_step("R4");
    chk(led == 8'h01, "R4 wrap", led, 8'h01);
    do_step("R4");
  endtask

  task automatic t_bounce();
    int top_hits = 0, low_hits = 0;
    sel = 2'b11;
    do_step("R6 load");
    for (int i = 0; i < 14; i++) begin
      do_step("R5");
      if (led == 8'h80) top_hits++;
      if (led == 8'h01) low_hits++;
    end
    chk(led == 8'h01, "R5 cycle", led, 8'h01);
    chk(top_hits == 1, "R5 top once", 8'(top_hits), 8'd1);
    chk(low_hits == 1, "R5 low once", 8'(low_hits), 8'd1);
  endtask

  task automatic t_switch();
    sel = 2'b11;
    for (int i = 0; i < 3; i++) do_step("R5");
    sel = 2'b01;
    do_step("R6 to twist");
    chk(led == 8'h00, "R6 twist start", led, 8'h00);
    sel = 2'b10;
    for (int i = 0; i < 3; i++) do_step("R4");
    sel = 2'b11;
    do_step("R6 rotate to sweep");
    chk(led == 8'h01, "R6 sweep start", led, 8'h01);
    for (int i = 0; i < 4; i++) do_step("R5");
    sel = 2'b10;
    do_step("R6 sweep to rotate");
    chk(led == 8'h01, "R6 rotate restart", led, 8'h01);
  endtask

  task automatic t_reset_mid();
    sel = 2'b10;
    do_step("R4");
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b0;
    #1 chk(led == 8'h00, "R1 async", led, 8'h00);
    @(posedge clk);
    #1 rst_ni = 1'b1;
    exp_led = 8'h00; exp_up = 1'b1; exp_mode = 0;
    do_step("R6 after reset");
    chk(led == 8'h01, "R1 restart", led, 8'h01);
  endtask

  initial begin
    t_reset();
    t_twist();
    t_alias();
    t_rotate();
    t_bounce();
    t_switch();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule